// File: doc/BRIEF.md
# Word-Wide Pin Port with Atomic Bit Operations

This block is a 32-pin general-purpose I/O port on a simple memory-mapped bus. Each transfer is one whole aligned word and has an address, a write enable, write data and read data. The port keeps three pieces of state:

- an output latch;
- a per-pin direction register;
- a synchronised copy of the pad input levels.

Three write-only alias addresses change chosen latch bits in a single bus write: one sets them, one clears them and one inverts them. Software therefore never needs a read-modify-write sequence, and a change to one pin cannot be lost because of a concurrent change to another pin.

Every pad gets an output value and an output enable for an external tri-state buffer. The output value is always the latch bit. The output enable is the direction bit. Pad inputs go through a two-flop synchronizer before they can be read.

Top module: `pio_word_port`

## Requirements
- R1: After reset the output latch and the direction register are all zeros, so `pad_oe` and `pad_out` are 0 and every pin is an input.
- R2: A write to word offset 0x00 loads the whole latch from `bus_wdata`. A read of 0x00 returns the latch.
- R3: A write to 0x04 sets to 1 each latch bit whose write-data bit is 1. All other latch bits keep their value.
- R4: A write to 0x08 clears to 0 each latch bit whose write-data bit is 1. All other latch bits keep their value.
- R5: A write to 0x0C inverts each latch bit whose write-data bit is 1. All other latch bits keep their value.
- R6: Reads of 0x04, 0x08 and 0x0C return 0.
- R7: A read of 0x10 returns the pad input levels after two synchronizer stages. A pad change is visible after the second rising clock edge, and not after the first.
- R8: Offset 0x14 is the read/write direction register, where 1 means output. `pad_oe` equals the direction bits.
- R9: `pad_out` equals the latch in every pin, whatever the direction.
- R10: Writes to 0x10 and to unmapped offsets change neither the latch nor the direction register. Reads of unmapped offsets return 0. Address bits [1:0] are ignored in decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the word accessed |
| bus_wen | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 means drive |

## Verification
The assertions assume that `bus_addr`, `bus_wen` and `bus_wdata` are stable around each rising clock edge. They also assume that `pad_in` only changes away from the edge, so the two-cycle synchronizer latency is exact.

The bench meets these assumptions by driving every input on the falling edge only. It then samples results half a period later, or just after a falling edge for combinational reads. It issues at most one write per cycle.

// File: rtl/pio_port_pkg.sv
package pio_port_pkg;

   localparam int unsigned BUS_W = 32;

   typedef enum logic [2:0] {
      SEL_DATA = 3'd0,
      SEL_SET  = 3'd1,
      SEL_CLR  = 3'd2,
      SEL_TGL  = 3'd3,
      SEL_IN   = 3'd4,
      SEL_DIR  = 3'd5,
      SEL_NONE = 3'd7
   } reg_sel_e;

   // word index of each register (byte offset / 4)
   localparam int unsigned WIDX_DATA = 0;
   localparam int unsigned WIDX_SET  = 1;
   localparam int unsigned WIDX_CLR  = 2;
   localparam int unsigned WIDX_TGL  = 3;
   localparam int unsigned WIDX_IN   = 4;
   localparam int unsigned WIDX_DIR  = 5;

endpackage

// File: rtl/pio_addr_dec.sv
module pio_addr_dec #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0]        addr,
   output pio_port_pkg::reg_sel_e   sel
);
   import pio_port_pkg::*;

   localparam int unsigned WORD_W = ADDR_W - 2;

   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("pio_addr_dec: ADDR_W must be at least 5");
   end

   logic [WORD_W-1:0] word_idx;
   logic [1:0]        unused_lsb;

   assign word_idx   = addr[ADDR_W-1:2];
   assign unused_lsb = addr[1:0];

   always_comb begin
      if      (word_idx == WORD_W'(WIDX_DATA)) sel = SEL_DATA;
      else if (word_idx == WORD_W'(WIDX_SET))  sel = SEL_SET;
      else if (word_idx == WORD_W'(WIDX_CLR))  sel = SEL_CLR;
      else if (word_idx == WORD_W'(WIDX_TGL))  sel = SEL_TGL;
      else if (word_idx == WORD_W'(WIDX_IN))   sel = SEL_IN;
      else if (word_idx == WORD_W'(WIDX_DIR))  sel = SEL_DIR;
      else                                     sel = SEL_NONE;
   end

endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] sync_q
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("pio_in_sync: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] stage_q [SYNC_STAGES];

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= pad_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_q = stage_q[SYNC_STAGES-1];

   if (SYNC_STAGES == 2) begin : g_chk_two
      logic [1:0] warm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             warm_q <= 2'd0;
         else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
      end
      AST_SYNC_TWO_CYCLES: assert property (@(posedge clk)
         disable iff (!rst_n || warm_q != 2'd2)
         sync_q == $past(pad_in, 2)); // R7
   end

endmodule

// File: rtl/pio_out_regs.sv
module pio_out_regs #(
   parameter int unsigned NUM_PINS = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wen,
   input  pio_port_pkg::reg_sel_e  sel,
   input  logic [NUM_PINS-1:0]     wdata,
   output logic [NUM_PINS-1:0]     latch_q,
   output logic [NUM_PINS-1:0]     dir_q
);
   import pio_port_pkg::*;

   logic [NUM_PINS-1:0] latch_d;

   always_comb begin
      latch_d = latch_q;
      if (wen) begin
         case (sel)
            SEL_DATA: latch_d = wdata;
            SEL_SET:  latch_d = latch_q | wdata;
            SEL_CLR:  latch_d = latch_q & ~wdata;
            SEL_TGL:  latch_d = latch_q ^ wdata;
            default:  latch_d = latch_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '0;
      end else begin
         latch_q <= latch_d;
         if (wen && sel == SEL_DIR) dir_q <= wdata;
      end
   end

   AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && sel == SEL_DATA) |=> latch_q == $past(wdata)); // R2
   AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && sel == SEL_SET) |=>
         ((latch_q & $past(wdata)) == $past(wdata)) &&
         ((latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata)))); // R3
   AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && sel == SEL_CLR) |=>
         ((latch_q & $past(wdata)) == '0) &&
         ((latch_q & ~$past(wdata)) == ($past(latch_q) & ~$past(wdata)))); // R4
   AST_TGL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (wen && sel == SEL_TGL) |=>
         ((latch_q ^ $past(latch_q)) == $past(wdata))); // R5
   AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wen || sel == SEL_IN || sel == SEL_NONE) |=>
         $stable(latch_q) && $stable(dir_q)); // R10

endmodule

// File: rtl/pio_word_port.sv
module pio_word_port #(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  bus_addr,
   input  logic        bus_wen,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic [31:0] pad_in,
   output logic [31:0] pad_out,
   output logic [31:0] pad_oe
);
   import pio_port_pkg::*;

   localparam int unsigned PAD_GAP = BUS_W - NUM_PINS;

   if (NUM_PINS < 1 || NUM_PINS > BUS_W) begin : g_bad_pins
      $error("pio_word_port: NUM_PINS must be 1..32");
   end
   if (ADDR_W != 8) begin : g_bad_aw
      $error("pio_word_port: port list fixes ADDR_W at 8");
   end

   reg_sel_e            sel;
   logic [NUM_PINS-1:0] latch_q;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] in_sync;
   logic [NUM_PINS-1:0] rd_pins;

   pio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr[ADDR_W-1:0]),
      .sel  (sel)
   );

   pio_out_regs #(.NUM_PINS(NUM_PINS)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wen     (bus_wen),
      .sel     (sel),
      .wdata   (bus_wdata[NUM_PINS-1:0]),
      .latch_q (latch_q),
      .dir_q   (dir_q)
   );

   pio_in_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pad_in (pad_in[NUM_PINS-1:0]),
      .sync_q (in_sync)
   );

   always_comb begin
      case (sel)
         SEL_DATA: rd_pins = latch_q;
         SEL_IN:   rd_pins = in_sync;
         SEL_DIR:  rd_pins = dir_q;
         default:  rd_pins = '0;
      endcase
   end

   if (PAD_GAP == 0) begin : g_full
      assign bus_rdata = rd_pins;
      assign pad_out   = latch_q;
      assign pad_oe    = dir_q;
   end else begin : g_narrow
      logic [PAD_GAP-1:0] unused_hi;
      assign unused_hi = bus_wdata[BUS_W-1:NUM_PINS] ^ pad_in[BUS_W-1:NUM_PINS];
      assign bus_rdata = {{PAD_GAP{1'b0}}, rd_pins};
      assign pad_out   = {{PAD_GAP{1'b0}}, latch_q};
      assign pad_oe    = {{PAD_GAP{1'b0}}, dir_q};
   end

   AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_SET || sel == SEL_CLR || sel == SEL_TGL) |-> bus_rdata == '0); // R6
   AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> bus_rdata == '0); // R10
   AST_DIR_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && sel == SEL_DIR) |=> pad_oe[NUM_PINS-1:0] == $past(bus_wdata[NUM_PINS-1:0])); // R8
   AST_PAD_OUT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wen && sel == SEL_DATA) |=> pad_out[NUM_PINS-1:0] == $past(bus_wdata[NUM_PINS-1:0])); // R9

endmodule

// File: tb/pio_word_port_test.sv
module pio_word_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = 32'h0;
   logic [31:0] pad_out;
   logic [31:0] pad_oe;

   int n_run = 0;
   int n_fail = 0;
   logic [31:0] exp_lat = 32'h0;
   logic [31:0] exp_dir = 32'h0;

   always #5 clk = ~clk;

   pio_word_port uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h00, v); check("R1 latch", v, 32'h0);
      rd(8'h14, v); check("R1 dir", v, 32'h0);
      check("R1 pad_oe", pad_oe, 32'h0);
      check("R1 pad_out", pad_out, 32'h0);
   endtask

   task automatic t_data();
      logic [31:0] v;
      wr(8'h00, 32'hA5A5_0F0F); exp_lat = 32'hA5A5_0F0F;
      rd(8'h00, v); check("R2 data readback", v, exp_lat);
      check("R9 pad_out while input", pad_out, exp_lat);
      check("R8 pad_oe still zero", pad_oe, 32'h0);
   endtask

   task automatic t_set();
      logic [31:0] v;
      wr(8'h04, 32'h0000_00F0); exp_lat = exp_lat | 32'h0000_00F0;
      rd(8'h00, v); check("R3 set", v, exp_lat);
      wr(8'h04, 32'h8000_0001); exp_lat = exp_lat | 32'h8000_0001;
      check("R3 set edge pins", pad_out, exp_lat);
      rd(8'h04, v); check("R6 set reads zero", v, 32'h0);
   endtask

   task automatic t_clear();
      logic [31:0] v;
      wr(8'h08, 32'hFF00_000F); exp_lat = exp_lat & ~32'hFF00_000F;
      rd(8'h00, v); check("R4 clear", v, exp_lat);
      rd(8'h08, v); check("R6 clear reads zero", v, 32'h0);
   endtask

   task automatic t_toggle();
      logic [31:0] v;
      wr(8'h0C, 32'hFFFF_0000); exp_lat = exp_lat ^ 32'hFFFF_0000;
      rd(8'h00, v); check("R5 toggle", v, exp_lat);
      wr(8'h0C, 32'hFFFF_0000); exp_lat = exp_lat ^ 32'hFFFF_0000;
      rd(8'h00, v); check("R5 toggle back", v, exp_lat);
      rd(8'h0C, v); check("R6 toggle reads zero", v, 32'h0);
   endtask

   task automatic t_dir();
      logic [31:0] v;
      wr(8'h14, 32'h0000_FFFF); exp_dir = 32'h0000_FFFF;
      rd(8'h14, v); check("R8 dir readback", v, exp_dir);
      check("R8 pad_oe", pad_oe, exp_dir);
      check("R9 pad_out with outputs", pad_out, exp_lat);
   endtask

   task automatic t_input();
      logic [31:0] v;
      @(negedge clk);
      bus_addr = 8'h10;
      pad_in = 32'h1234_5678;
      @(negedge clk);
      #1 check("R7 not after one edge", bus_rdata, 32'h0);
      @(negedge clk);
      #1 check("R7 after two edges", bus_rdata, 32'h1234_5678);
      pad_in = 32'hCAFE_F00D;
      rd(8'h10, v); check("R7 old value after one edge", v, 32'h1234_5678);
      rd(8'h10, v); check("R7 second pattern", v, 32'hCAFE_F00D);
   endtask

   task automatic t_ignored();
      logic [31:0] v;
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'hFC, 32'hFFFF_FFFF);
      rd(8'h00, v); check("R10 latch untouched", v, exp_lat);
      rd(8'h14, v); check("R10 dir untouched", v, exp_dir);
      rd(8'h18, v); check("R10 unmapped read zero", v, 32'h0);
      wr(8'h07, 32'h0000_0100); exp_lat = exp_lat | 32'h0000_0100;
      rd(8'h02, v); check("R10 low address bits ignored", v, exp_lat);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_data();
      t_set();
      t_clear();
      t_toggle();
      t_dir();
      t_input();
      t_ignored();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #200000;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule